// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that gives a bus master read and write access to a bank of 47 byte-wide control registers at addresses 0x00 to 0x2E. Both bus lines are brought into the system clock domain through flip-flop synchronizers. Start, repeated start and stop conditions and clock edges are detected there, and the data line is driven only through an active-high pull-low enable.

A write transaction names the device, then sends a one-byte register pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps up by one until it reaches the top register. A read transaction returns bytes starting at the pointer left by an earlier transaction and steps the pointer the same way. A strap input picks one of two device addresses, so two of these slaves can share one bus. A side read port exposes the register bank for checking.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), every register reads 0 and the register pointer is 0x00.
- R2: `sda_oe` changes only while the synchronized clock line is low. A fall of the data line while the clock line is high is a start, and a rise of the data line while the clock line is high is a stop.
- R3: Bytes are sent MSB first. The first byte after a start holds the 7-bit device address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The device address is 0x4C when `addr_sel` = 0 and 0x4D when `addr_sel` = 1. On a match the slave pulls the data line low for the whole ninth clock pulse.
- R4: On an address mismatch the slave does not acknowledge and ignores every byte until the next start. No register and no pointer value changes.
- R5: In a write, the byte after the address is loaded into the pointer and acknowledged. Each later data byte is acknowledged, stored at the pointer, and the pointer is then incremented.
- R6: The pointer saturates at 0x2E. Further writes all land in register 0x2E, and further reads all return register 0x2E.
- R7: A pointer byte above 0x2E gets no acknowledge. The pointer is unchanged, and the rest of the transaction is ignored.
- R8: In a read, the slave sends the register at the pointer. After each byte the pointer increments, and a master acknowledge (data low on the ninth pulse) leads to the next byte.
- R9: A master no-acknowledge (data high on the ninth pulse) ends the read, and the data line stays released.
- R10: A repeated start begins a new address phase at once, so a pointer write can be followed by a read without a stop.
- R11: The pointer keeps its value across a stop, so a later read continues from it.
- R12: A stop at any point, including within a byte, returns the slave to idle, and a partly received data byte is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_sel | input | 1 | Strap that selects the device address LSB |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dbg_addr | input | 6 | Side-port register index |
| dbg_data | output | 8 | Side-port register contents at `dbg_addr` |

## Verification
Two situations are hard to reach from the pins. One is a pointer that has saturated while later bytes keep arriving, in either direction. The other is a stop that arrives with a data byte only partly shifted in. The bench reaches the first with directed writes and reads that begin at 0x2C and 0x2D and run past the top. It reaches the second by aborting a byte after four bits. Random transactions then mix in-range and out-of-range pointers, wrong device addresses, strap changes and write-then-repeated-start reads. They are checked against a byte-level model of the register bank and pointer, and the bank is compared in full through the side port.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_RNEXT
  } twi_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } twi_kind_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } twi_line_ev_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
  import twi_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  output twi_line_ev_t ev,
  output logic         scl_lvl
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_s;
  logic              sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_comb begin
    ev.rise  = scl_s & ~scl_prev;
    ev.fall  = ~scl_s & scl_prev;
    ev.start = scl_s & scl_prev & sda_prev & ~sda_s;
    ev.stop  = scl_s & scl_prev & ~sda_prev & sda_s;
    ev.sda   = sda_s;
  end

  assign scl_lvl = scl_s;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int DEPTH = 47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hit[g] = wr_en && (wr_addr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i]) mem_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data  = '0;
    dbg_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == AW'(i))  rd_data  = mem_q[i];
      if (dbg_addr == AW'(i)) dbg_data = mem_q[i];
    end
  end

endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             AW       = 6,
  parameter int             TOP_ADDR = 46,
  parameter logic [DW-3:0]  DEV_HI   = 6'b100110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  twi_line_ev_t  ev,
  input  logic          addr_sel,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe
);

  localparam int            CW       = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);
  localparam logic [AW-1:0] PTR_TOP  = AW'(TOP_ADDR);

  twi_state_e    st_q, st_d;
  twi_kind_e     kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic          half_q, half_d;

  logic [DW-1:0] byte_in;
  logic [DW-2:0] dev_addr;
  logic [AW-1:0] ptr_next;

  assign byte_in  = {sh_q[DW-2:0], ev.sda};
  assign dev_addr = {DEV_HI, addr_sel};
  assign ptr_next = (ptr_q == PTR_TOP) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    half_d  = half_q;
    wr_en   = 1'b0;

    if (ev.stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (ev.start) begin
      st_d   = ST_RECV;
      kind_d = K_ADDR;
      cnt_d  = '0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RECV: begin
          if (ev.rise) begin
            sh_d  = byte_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_d  = '0;
              half_d = 1'b0;
              st_d   = ST_ACK;
              case (kind_q)
                K_ADDR: begin
                  rw_d = byte_in[0];
                  if (byte_in[DW-1:1] != dev_addr) st_d = ST_IDLE;
                end
                K_PTR: begin
                  if (byte_in > DW'(TOP_ADDR)) st_d = ST_IDLE;
                  else ptr_d = byte_in[AW-1:0];
                end
                default: begin
                  wr_en = 1'b1;
                  ptr_d = ptr_next;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (ev.fall) begin
            if (!half_q) begin
              oe_d   = 1'b1;
              half_d = 1'b1;
            end else begin
              oe_d  = 1'b0;
              cnt_d = '0;
              if (kind_q == K_ADDR && rw_q) begin
                sh_d = rd_data;
                oe_d = ~rd_data[DW-1];
                st_d = ST_SEND;
              end else begin
                st_d   = ST_RECV;
                kind_d = (kind_q == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
        end
        ST_SEND: begin
          if (ev.fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d = 1'b0;
              st_d = ST_MACK;
            end else begin
              oe_d  = ~sh_q[DW-2];
              sh_d  = {sh_q[DW-2:0], sh_q[DW-1]};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (ev.rise) begin
            ptr_d = ptr_next;
            st_d  = ev.sda ? ST_IDLE : ST_RNEXT;
          end
        end
        ST_RNEXT: begin
          if (ev.fall) begin
            sh_d  = rd_data;
            oe_d  = ~rd_data[DW-1];
            cnt_d = '0;
            st_d  = ST_SEND;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      half_q <= half_d;
    end
  end

  assign wr_addr = ptr_q;
  assign wr_data = byte_in;
  assign ptr_o   = ptr_q;
  assign sda_oe  = oe_q;

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            TOP_ADDR = 46,
  parameter int            SYNC     = 2,
  parameter logic [DW-3:0] DEV_HI   = 6'b100110,
  localparam int           DEPTH    = TOP_ADDR + 1,
  localparam int           AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  twi_line_ev_t  ev;
  logic          scl_s;
  logic          start_ev;
  logic          stop_ev;
  logic          scl_rise;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  twi_line_sync #(.STAGES(SYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .ev      (ev),
    .scl_lvl (scl_s)
  );

  assign start_ev = ev.start;
  assign stop_ev  = ev.stop;
  assign scl_rise = ev.rise;

  twi_slave_ctrl #(
    .DW       (DW),
    .AW       (AW),
    .TOP_ADDR (TOP_ADDR),
    .DEV_HI   (DEV_HI)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ev       (ev),
    .addr_sel (addr_sel),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr_o    (ptr),
    .sda_oe   (sda_oe)
  );

  twi_reg_bank #(
    .DW    (DW),
    .AW    (AW),
    .DEPTH (DEPTH)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (ptr),
    .rd_data  (rd_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
  parameter int AW       = 6,
  parameter int TOP_ADDR = 46
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          scl_rise,
  input logic [AW-1:0] ptr
);

  // R2: the pull-low enable holds still while the clock line stays high
  assert_oe_still_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> (sda_oe == $past(sda_oe)));

  // R2: start and stop are never seen together
  assert_cond_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));

  // R12: a stop leaves the data line released
  assert_stop_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R10: a (repeated) start leaves the data line released for the address phase
  assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R6: pointer never passes the top register
  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= AW'(TOP_ADDR));

  // R11: the pointer moves only on a clock-line rise
  assert_ptr_moves_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(scl_rise));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(
  .AW       (AW),
  .TOP_ADDR (TOP_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .scl_rise (scl_rise),
  .ptr      (ptr)
);

// File: tb/tb_twi_reg_slave.sv
module tb_twi_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int TOPA       = 46;
  localparam int NREG       = TOPA + 1;
  localparam logic [6:0] DEV0 = 7'h4C;
  localparam logic [6:0] DEV1 = 7'h4D;

  logic       clk;
  logic       rst_n;
  logic       addr_sel;
  logic       scl_m;
  logic       sda_m;
  logic       sda_oe;
  logic       sda_bus;
  logic [5:0] dbg_addr;
  logic [7:0] dbg_data;

  int         n_chk;
  int         n_fail;
  int         oe_viol;
  logic       oe_prev;
  logic [7:0] mem_m [NREG];
  int         ptr_m;

  assign sda_bus = sda_m & ~sda_oe;

  twi_reg_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_sel (addr_sel),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // R2 monitor: the enable may only move while the clock line is low
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != oe_prev && scl_m) oe_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat_inc(input int p);
    return (p == TOPA) ? p : p + 1;
  endfunction

  function automatic logic [6:0] own_dev();
    return addr_sel ? DEV1 : DEV0;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2 * Q);
      scl_m = 1'b0; wait_clk(Q);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    put_bits(b, 8);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    ack = ~sda_bus; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      b = {b[6:0], sda_bus}; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
    end
    sda_m = nack; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2 * Q);
    scl_m = 1'b0; wait_clk(Q);
    sda_m = 1'b1;
  endtask

  task automatic compare_all(input string req);
    int bad;
    int first_a;
    bad = 0;
    first_a = 0;
    for (int a = 0; a < NREG; a++) begin
      dbg_addr = 6'(a);
      #1;
      if (dbg_data !== mem_m[a]) begin
        if (bad == 0) first_a = a;
        bad++;
      end
    end
    dbg_addr = 6'(first_a);
    #1;
    check(bad == 0, req, int'(dbg_data), int'(mem_m[first_a]));
  endtask

  // body of a read after the read address was acknowledged
  task automatic read_body(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      check(b == mem_m[ptr_m], req, int'(b), int'(mem_m[ptr_m]));
      ptr_m = sat_inc(ptr_m);
    end
    check(sda_oe == 1'b0, "R9 released after master nack", int'(sda_oe), 0);
  endtask

  // write: address, pointer, n data bytes; bytes sent even when refused
  task automatic do_write(input logic [6:0] dev, input logic [7:0] p, input int n,
                          input string req);
    bit ack;
    bit live;
    logic [7:0] d;
    bus_start();
    put_byte({dev, 1'b0}, ack);
    live = (dev == own_dev());
    check(ack == live, live ? "R3 address ack" : "R4 address refused", int'(ack), int'(live));
    if (live) begin
      put_byte(p, ack);
      live = (p <= 8'(TOPA));
      check(ack == live, live ? "R5 pointer ack" : "R7 pointer refused", int'(ack), int'(live));
      if (live) ptr_m = int'(p);
    end
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ack);
      check(ack == live, live ? req : "R4 R7 ignored byte", int'(ack), int'(live));
      if (live) begin
        mem_m[ptr_m] = d;
        ptr_m = sat_inc(ptr_m);
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input int n, input string req);
    bit ack;
    bit live;
    bus_start();
    put_byte({dev, 1'b1}, ack);
    live = (dev == own_dev());
    check(ack == live, "R3 read address ack", int'(ack), int'(live));
    if (live) read_body(n, req);
    bus_stop();
  endtask

  // pointer write followed by repeated start and read
  task automatic do_ptr_read(input logic [7:0] p, input int n, input string req);
    bit ack;
    bit live;
    bus_start();
    put_byte({own_dev(), 1'b0}, ack);
    check(ack == 1'b1, "R3 address ack", int'(ack), 1);
    put_byte(p, ack);
    live = (p <= 8'(TOPA));
    check(ack == live, live ? "R5 pointer ack" : "R7 pointer refused", int'(ack), int'(live));
    if (live) ptr_m = int'(p);
    bus_start();
    put_byte({own_dev(), 1'b1}, ack);
    check(ack == 1'b1, "R10 repeated start read ack", int'(ack), 1);
    read_body(n, req);
    bus_stop();
  endtask

  task automatic finish_run();
    check(oe_viol == 0, "R2 enable moved while clock high", oe_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    int kind;
    int n;
    logic [7:0] p;
    n_chk = 0;
    n_fail = 0;
    oe_viol = 0;
    oe_prev = 1'b0;
    ptr_m = 0;
    for (int i = 0; i < NREG; i++) mem_m[i] = '0;
    void'($urandom(32'h1357_2468));
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    addr_sel = 1'b0;
    dbg_addr = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);

    // R1: reset state
    check(sda_oe == 1'b0, "R1 line released", int'(sda_oe), 0);
    compare_all("R1 registers zero");
    do_read(DEV0, 2, "R1 pointer starts at zero");

    // R5 / R3: write with strap 0
    do_write(DEV0, 8'h10, 3, "R5 data ack");
    compare_all("R5 bytes stored with increment");

    // R4: wrong device address, trailing bytes ignored
    do_write(DEV1, 8'h20, 2, "R4 ignored");
    compare_all("R4 registers unchanged");

    // R3: strap 1 selects the other address
    addr_sel = 1'b1;
    do_write(DEV1, 8'h21, 2, "R3 strap high write");
    do_write(DEV0, 8'h22, 1, "R4 old address refused");
    compare_all("R3 strap selects address");
    addr_sel = 1'b0;

    // R6: write past the top register
    do_write(DEV0, 8'h2C, 5, "R6 saturating write");
    compare_all("R6 top register holds last byte");

    // R7: out-of-range pointers
    do_write(DEV0, 8'h2F, 2, "R7 ignored");
    do_write(DEV0, 8'hFF, 1, "R7 ignored");
    compare_all("R7 registers unchanged");
    do_read(DEV0, 1, "R7 pointer unchanged");

    // R8 / R10: pointer then repeated start read
    do_ptr_read(8'h10, 3, "R8 sequential read");
    // R11: pointer survives the stop
    do_read(DEV0, 2, "R11 read continues from kept pointer");
    // R6: saturating read
    do_ptr_read(8'h2D, 3, "R6 saturating read");

    // R12: stop in the middle of a data byte
    bus_start();
    put_byte({DEV0, 1'b0}, ack);
    check(ack == 1'b1, "R12 address ack", int'(ack), 1);
    put_byte(8'h05, ack);
    check(ack == 1'b1, "R12 pointer ack", int'(ack), 1);
    ptr_m = 5;
    put_bits(8'hA5, 4);
    bus_stop();
    check(sda_oe == 1'b0, "R12 idle after stop", int'(sda_oe), 0);
    compare_all("R12 partial byte not stored");
    do_read(DEV0, 1, "R12 pointer kept after abort");

    // random mix
    for (int t = 0; t < 24; t++) begin
      kind = int'($urandom % 5);
      n = 1 + int'($urandom % 4);
      if (($urandom % 6) == 0) addr_sel = ~addr_sel;
      p = (($urandom % 4) == 0) ? 8'(47 + ($urandom % 209)) : 8'($urandom % NREG);
      case (kind)
        0, 1: do_write(own_dev(), p, n, "R5 random write");
        2: do_read(own_dev(), n, "R8 random read");
        3: do_ptr_read(8'($urandom % NREG), n, "R10 random pointer read");
        default: do_write(own_dev() ^ 7'h01, p, n, "R4 random wrong address");
      endcase
    end
    compare_all("R5 R6 R7 final bank");

    finish_run();
  end

endmodule